// File: doc/BRIEF.md
# Free-Running Line Sync and NMI Generator

This block produces the horizontal timing of a small CPU-driven video system. A line counter runs on the rising edge of the CPU clock and never stops. Once per line it opens a fixed-width window that pulls the composite sync output low. The counter is re-aligned only when the CPU acknowledges an interrupt, meaning the machine cycle where /M1 and /IORQ are low together. Frame (vertical) sync never restarts it. Horizontal pulses therefore keep their exact spacing no matter what software does with the frame sync.

A mode flag lets the same line window also drive the active-low NMI output. Software uses this to count blank margin lines. The flag and the frame sync are controlled by partially decoded I/O cycles that look only at the three low address bits:
- A write ending in binary 110 turns the NMI generator on.
- A write ending in 101 turns it off.
- A keyboard-style read (bit 0 low, bit 2 high) starts frame sync, but only while the NMI generator is off.
- Any write ends frame sync.

The composite output is the AND of both active-low syncs. The frame-sync state is also brought out as a separate active-high flag.

Top module: `line_sync_nmi_gen`

## Requirements
- R1: While rst_n is low, and on the cycle reset ends, csync_n=1, nmi_n=1 and vsync=0. The NMI enable and frame-sync flags are cleared, and the line phase is 0.
- R2: The line phase advances by one on every rising clock edge and wraps from LINE_CYCLES-1 (default 206) to 0. This gives a line of 207 cycles with one sync pulse per line, whatever the state of the NMI enable.
- R3: Counting from the cycle of phase 0 (the cycle after the last edge that saw reset or an interrupt acknowledge), the horizontal pulse covers phases 16 through 31. csync_n goes low after the 16th rising edge and high again after the 16th edge following the fall.
- R4: While iorq_n=0 and m1_n=0 are sampled at an edge, the phase is set to 0. No other input realigns the line.
- R5: Starting or ending frame sync leaves the line phase unchanged.
- R6: When the NMI generator is on, nmi_n is low in exactly the cycles of the horizontal pulse. When it is off, nmi_n stays high.
- R7: An I/O write whose addr[2:0]=110 turns the NMI generator on, and one with addr[2:0]=101 turns it off. Other low-bit values (for example 111) leave it unchanged, and address bits above bit 2 are ignored.
- R8: An I/O read with addr[0]=0 and addr[2]=1 sets the frame-sync flag, but only while the NMI generator is off. Reads with addr[0]=1 or addr[2]=0 do not set it.
- R9: Any I/O write clears the frame-sync flag. A write takes priority over a simultaneous read.
- R10: csync_n is low whenever the horizontal pulse or the frame sync is active. vsync is 1 exactly while the frame-sync flag is set.
- R11: A cycle counts as a port access only with iorq_n=0 and m1_n=1. During an interrupt acknowledge, rd_n or wr_n low have no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Low CPU address bits |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| csync_n | output | 1 | Composite sync, active low |
| vsync | output | 1 | Frame-sync flag, active high |

## Verification
The bench builds the block with its defaults: a 207-cycle line, the pulse at phase 16 lasting 16 cycles, and an 8-bit address. With these values several whole lines pass between port accesses, so each run of expectations covers wraps of the counter as well as the pulse edges. The 8-bit address lets upper bits differ while the low three match, which exercises the partial decode. Interrupt acknowledges are placed at arbitrary phases, some carrying stray read or write strobes. Frame sync is opened and closed mid-line and then checked against the original phase.

// File: rtl/lsn_pkg.sv
`timescale 1ns/1ps
package lsn_pkg;
   // Low-bit port codes; the CPU software depends on these exact values
   localparam logic [2:0] NMI_ON_CODE  = 3'b110;
   localparam logic [2:0] NMI_OFF_CODE = 3'b101;

   typedef struct packed {
      logic nmi_on;
      logic nmi_off;
      logic kbd_rd;
      logic any_wr;
   } port_ev_t;
endpackage

// File: rtl/lsn_port_decode.sv
`timescale 1ns/1ps
module lsn_port_decode
   import lsn_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output port_ev_t          ev,
   output logic              intack
);
   logic io_cyc, io_wr, io_rd;

   always_comb begin
      io_cyc    = !iorq_n && m1_n;
      io_wr     = io_cyc && !wr_n;
      io_rd     = io_cyc && !rd_n;
      intack    = !iorq_n && !m1_n;
      ev.any_wr  = io_wr;
      ev.nmi_on  = io_wr && (addr[2:0] == NMI_ON_CODE);
      ev.nmi_off = io_wr && (addr[2:0] == NMI_OFF_CODE);
      ev.kbd_rd  = io_rd && !addr[0] && addr[2];
   end

   // Upper address bits take no part in the decode
   generate
      if (ADDR_W > 3) begin : g_hi
         logic unused_addr_hi;
         assign unused_addr_hi = ^addr[ADDR_W-1:3];
      end
   endgenerate
endmodule

// File: rtl/lsn_line_counter.sv
`timescale 1ns/1ps
module lsn_line_counter #(
   parameter int LINE_CYCLES = 207,
   parameter int CNT_W       = $clog2(LINE_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             intack,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (intack || cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/lsn_mode_regs.sv
`timescale 1ns/1ps
module lsn_mode_regs
   import lsn_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  port_ev_t ev,
   output logic     nmi_en,
   output logic     vs_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_en  <= 1'b0;
         vs_flag <= 1'b0;
      end else begin
         if (ev.nmi_on)
            nmi_en <= 1'b1;
         else if (ev.nmi_off)
            nmi_en <= 1'b0;
         // a write ends frame sync and wins over any read
         if (ev.any_wr)
            vs_flag <= 1'b0;
         else if (ev.kbd_rd && !nmi_en)
            vs_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/lsn_sync_out.sv
`timescale 1ns/1ps
module lsn_sync_out #(
   parameter int CNT_W    = 8,
   parameter int SYNC_AT  = 16,
   parameter int SYNC_LEN = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             nmi_en,
   input  logic             vs_flag,
   output logic             nmi_n,
   output logic             csync_n,
   output logic             vsync
);
   localparam logic [CNT_W-1:0] P_LO = CNT_W'(SYNC_AT);
   localparam logic [CNT_W-1:0] P_HI = CNT_W'(SYNC_AT + SYNC_LEN);

   logic hs_act;

   always_comb begin
      hs_act  = (cnt >= P_LO) && (cnt < P_HI);
      nmi_n   = !(hs_act && nmi_en);
      csync_n = !(hs_act || vs_flag);
      vsync   = vs_flag;
   end
endmodule

// File: rtl/line_sync_nmi_gen.sv
`timescale 1ns/1ps
module line_sync_nmi_gen
   import lsn_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int LINE_CYCLES = 207,
   parameter int SYNC_AT     = 16,
   parameter int SYNC_LEN    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              nmi_n,
   output logic              csync_n,
   output logic              vsync
);
   localparam int CNT_W = $clog2(LINE_CYCLES);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover the three decoded bits");
      end
      if (SYNC_LEN < 1) begin : g_bad_len
         $error("SYNC_LEN must be at least one cycle");
      end
      if (SYNC_AT + SYNC_LEN > LINE_CYCLES) begin : g_bad_win
         $error("sync window must fit inside one line");
      end
   endgenerate

   port_ev_t         ev;
   logic             intack;
   logic [CNT_W-1:0] cnt_q;
   logic             nmi_en_q;
   logic             vs_q;

   lsn_port_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
      .ev(ev), .intack(intack)
   );

   lsn_line_counter #(.LINE_CYCLES(LINE_CYCLES), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .intack(intack), .cnt(cnt_q)
   );

   lsn_mode_regs u_mode (
      .clk(clk), .rst_n(rst_n), .ev(ev), .nmi_en(nmi_en_q), .vs_flag(vs_q)
   );

   lsn_sync_out #(.CNT_W(CNT_W), .SYNC_AT(SYNC_AT), .SYNC_LEN(SYNC_LEN)) u_out (
      .cnt(cnt_q), .nmi_en(nmi_en_q), .vs_flag(vs_q),
      .nmi_n(nmi_n), .csync_n(csync_n), .vsync(vsync)
   );
endmodule

// File: rtl/lsn_checker.sv
`timescale 1ns/1ps
module lsn_checker #(
   parameter int ADDR_W      = 8,
   parameter int LINE_CYCLES = 207,
   parameter int CNT_W       = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              iorq_n,
   input logic              m1_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              nmi_n,
   input logic              csync_n,
   input logic              vsync,
   input logic [CNT_W-1:0]  cnt,
   input logic              nmi_en
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_CYCLES - 1);

   logic io_c, ack_c;
   assign io_c  = !iorq_n && m1_n;
   assign ack_c = !iorq_n && !m1_n;

   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST) |=> (cnt == '0));                                   // R2
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_c && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));     // R5
   AST_ACK_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ack_c |=> (cnt == '0));                                           // R4
   AST_NMI_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_n |-> (!csync_n && nmi_en));                                 // R6
   AST_NMI_OFF_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (io_c && !wr_n && addr[2:0] == 3'b101) |=> nmi_n);                // R7
   AST_VS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (io_c && !rd_n && wr_n && !addr[0] && addr[2] && !nmi_en) |=> vsync); // R8
   AST_VS_END: assert property (@(posedge clk) disable iff (!rst_n)
      (io_c && !wr_n) |=> !vsync);                                      // R9
   AST_VS_COMPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> !csync_n);                                              // R10
   AST_ACK_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      ack_c |=> (vsync == $past(vsync) || !vsync));                     // R11
endmodule

bind line_sync_nmi_gen lsn_checker #(
   .ADDR_W(ADDR_W), .LINE_CYCLES(LINE_CYCLES), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
   .rd_n(rd_n), .wr_n(wr_n), .nmi_n(nmi_n), .csync_n(csync_n), .vsync(vsync),
   .cnt(cnt_q), .nmi_en(nmi_en_q)
);

// File: tb/sim_line_sync_nmi_gen.sv
`timescale 1ns/1ps
module sim_line_sync_nmi_gen;
   localparam int AW     = 8;
   localparam int LINE   = 207;
   localparam int HS_AT  = 16;
   localparam int HS_LEN = 16;

   typedef struct {
      int    cyc;
      bit    cs;
      bit    nm;
      bit    vs;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '1;
   logic          iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic          nmi_n, csync_n, vsync;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   line_sync_nmi_gen #(.ADDR_W(AW), .LINE_CYCLES(LINE), .SYNC_AT(HS_AT), .SYNC_LEN(HS_LEN)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
      .rd_n(rd_n), .wr_n(wr_n), .nmi_n(nmi_n), .csync_n(csync_n), .vsync(vsync)
   );

   // monitor: compare the head of the scoreboard in its cycle
   always @(negedge clk) begin
      exp_t e;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         e = q.pop_front();
         n_chk++;
         if (e.cyc != cyc) begin
            n_fail++;
            $display("FAIL %s: item for cycle %0d missed (actual cycle %0d)", e.tag, e.cyc, cyc);
         end else if (csync_n !== e.cs || nmi_n !== e.nm || vsync !== e.vs) begin
            n_fail++;
            $display("FAIL %s cyc %0d: actual csync_n=%b nmi_n=%b vsync=%b expected %b %b %b",
                     e.tag, cyc, csync_n, nmi_n, vsync, e.cs, e.nm, e.vs);
         end
      end
   end

   // driver: expected outputs from line origin r, NMI enable and frame sync
   task automatic expect_window(input int r, input int from, input int to,
                                input bit ne, input bit vs, input string tag);
      exp_t e;
      for (int c = from; c <= to; c++) begin
         int ph;
         bit hs;
         ph = (c - r) % LINE;
         hs = (ph >= HS_AT) && (ph < HS_AT + HS_LEN);
         e.cyc = c;
         e.cs  = !(hs || vs);
         e.nm  = !(hs && ne);
         e.vs  = vs;
         e.tag = tag;
         q.push_back(e);
      end
      while (cyc <= to) @(posedge clk);
      #1;
   endtask

   task automatic io_write(input logic [AW-1:0] a);
      @(posedge clk); #1;
      addr = a; iorq_n = 1'b0; wr_n = 1'b0;
      @(posedge clk); #1;
      iorq_n = 1'b1; wr_n = 1'b1; addr = '1;
   endtask

   task automatic io_read(input logic [AW-1:0] a);
      @(posedge clk); #1;
      addr = a; iorq_n = 1'b0; rd_n = 1'b0;
      @(posedge clk); #1;
      iorq_n = 1'b1; rd_n = 1'b1; addr = '1;
   endtask

   // interrupt acknowledge, optionally with stray strobes; returns new origin
   task automatic intack(input bit stray_wr, input bit stray_rd,
                         input logic [AW-1:0] a, output int r);
      @(posedge clk); #1;
      addr = a; m1_n = 1'b0; iorq_n = 1'b0;
      wr_n = !stray_wr; rd_n = !stray_rd;
      @(posedge clk); #1;
      m1_n = 1'b1; iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; addr = '1;
      r = cyc;
   endtask

   initial begin
      int r;
      repeat (3) @(posedge clk);
      #1;
      expect_window(cyc, cyc, cyc, 1'b0, 1'b0, "R1 reset state");
      rst_n = 1'b1;
      r = cyc;
      expect_window(r, cyc, cyc, 1'b0, 1'b0, "R1 reset release");
      expect_window(r, cyc, cyc + 3*LINE, 1'b0, 1'b0, "R2 R3 free-running line");
      io_write(8'hF6);
      expect_window(r, cyc, cyc + 2*LINE, 1'b1, 1'b0, "R6 R7 nmi on via xx110");
      io_read(8'hFE);
      expect_window(r, cyc, cyc + LINE, 1'b1, 1'b0, "R8 kbd read ignored with nmi on");
      io_write(8'hFF);
      expect_window(r, cyc, cyc + LINE, 1'b1, 1'b0, "R7 code 111 leaves nmi on");
      io_write(8'h05);
      expect_window(r, cyc, cyc + LINE, 1'b0, 1'b0, "R7 nmi off via xx101");
      io_read(8'hFF);
      expect_window(r, cyc, cyc + 40, 1'b0, 1'b0, "R8 read bit0 high no vsync");
      io_read(8'hFA);
      expect_window(r, cyc, cyc + 40, 1'b0, 1'b0, "R8 read bit2 low no vsync");
      io_read(8'h7E);
      expect_window(r, cyc, cyc + LINE + 30, 1'b0, 1'b1, "R8 R10 frame sync on");
      io_write(8'hFF);
      expect_window(r, cyc, cyc + 2*LINE, 1'b0, 1'b0, "R5 R9 frame sync end keeps phase");
      intack(1'b1, 1'b0, 8'hF6, r);
      expect_window(r, cyc, cyc + 2*LINE, 1'b0, 1'b0, "R4 R11 realign, stray write ignored");
      io_read(8'h7E);
      expect_window(r, cyc, cyc + 60, 1'b0, 1'b1, "R8 frame sync on again");
      intack(1'b1, 1'b1, 8'hFE, r);
      expect_window(r, cyc, cyc + LINE, 1'b0, 1'b1, "R11 R5 acknowledge keeps frame sync");
      io_write(8'hF6);
      expect_window(r, cyc, cyc + 100, 1'b1, 1'b0, "R9 R7 write ends frame sync and enables nmi");
      intack(1'b0, 1'b0, 8'hFF, r);
      expect_window(r, cyc, cyc + 2*LINE, 1'b1, 1'b0, "R4 R6 nmi follows realigned line");
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected end of test", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule